// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing FIFO with Rewind

This block is a first-in first-out buffer between a write clock domain and a read clock domain. Its storage array and pointer depth are set by parameters. A read timing mode is captured while master reset is held. In standard mode a word waits in the array until the reader asks for it. In fall-through mode the oldest word is moved into the output register by itself, and the reader sees it without asking. The read-side and write-side status pins change meaning with the mode. A half-full flag and a write-domain occupancy count are provided for a companion threshold block.

Partial reset empties the buffer but keeps the mode chosen at master reset. A rewind input moves only the read pointer back to the first array location, so data that has already been read can be replayed. An output-enable input forces the data bus to zero when it is low.

The read side is run by a two-state machine. The states are RS_DRAINED, where no word is held for the reader, and RS_HOLDING, where the output register holds the head word. The machine has four transitions:
- The fetch transition goes from RS_DRAINED to RS_HOLDING when the array has a word.
- The advance transition stays in RS_HOLDING when the reader consumes the held word and another word is present.
- The drain transition goes from RS_HOLDING to RS_DRAINED when the reader consumes the held word and the array is empty.
- The rewind transition goes from any state to RS_DRAINED.

Standard mode does not use the machine and stays in RS_DRAINED.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst_n` is low at a clock edge, `mode_sel` is captured in both domains: 0 selects standard mode and 1 selects fall-through mode. `mode_sel` has no effect at any other time. After master reset, `level` is 0 and the output register is 0. In standard mode `rd_flag` is 1 and `wr_flag` is 0. In fall-through mode `rd_flag` is 0 and `wr_flag` is 1.
- R2: In standard mode a written word does not reach `dout` until a `rd_clk` rising edge with `rd_en` high and the array non-empty. `dout` shows that word after this edge.
- R3: In fall-through mode, a word written into an empty buffer appears on `dout` after the third `rd_clk` rising edge that follows the write edge, with no `rd_en`, and `rd_flag` rises at the same edge. Each later word needs `rd_en` high on an edge while `rd_flag` is 1.
- R4: In standard mode, `rd_flag` is 1 when the array is empty, and `wr_flag` is 1 when the array is full (DEPTH words). In fall-through mode, `rd_flag` is 1 when the output register holds a valid word, and `wr_flag` is 1 while the array is not full. Fall-through mode therefore holds DEPTH+1 words.
- R5: `half_flag` is 1 exactly when `level` is greater than DEPTH/2, in both modes.
- R6: A write while the array is full is dropped. The write pointer does not move, and that word is never read out.
- R7: A read when the array is empty (standard mode) or when no word is held (fall-through mode) has no effect: the read pointer and `dout` are unchanged.
- R8: Partial reset (`prst_n` low) empties the buffer and clears `level` and the output register. It keeps the captured mode, and `mode_sel` is ignored during it.
- R9: `rt_n` low on a `rd_clk` rising edge sets the read pointer to the first array location, and it takes priority over a read at the same edge. The following reads replay from the first word written after reset. In fall-through mode the output register is then refilled with that word.
- R10: While `oe` is low, `dout` is all zeros. While `oe` is high, `dout` shows the output register.
- R11: `level` is the number of words in the array as seen in the write domain. In fall-through mode the word held in the output register is not counted.
- R12: Words leave the buffer in the order in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| prst_n | input | 1 | Partial reset, active low, keeps the mode |
| mode_sel | input | 1 | Mode captured during master reset (0 standard, 1 fall-through) |
| wr_en | input | 1 | Write request |
| din | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rt_n | input | 1 | Rewind the read pointer, active low |
| oe | input | 1 | Output enable for `dout` |
| dout | output | DW | Read data |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_flag | output | 1 | Occupancy above half the depth |
| level | output | $clog2(DEPTH)+1 | Array occupancy in the write domain |

## Verification
The bench sweeps fill level from empty to one word past capacity in both modes, and after every write it checks `level`, `half_flag` and the mode-specific meaning of `wr_flag`. A design that counted the held fall-through word, or that let an extra write through, fails at the top of this sweep. The fall-through latency is checked edge by edge, so a design that passes the word through one synchronizer stage too many or too few shows the word at the wrong edge. Reads on an empty buffer, a rewind after a full drain, and a partial reset taken while `mode_sel` is driven to the other mode each expose a specific fault: a read pointer that slips, a replay that starts from the wrong word, or a mode lost on partial reset.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    typedef enum logic {
        RS_DRAINED = 1'b0,
        RS_HOLDING = 1'b1
    } rd_state_e;
endpackage

// File: rtl/dmfifo_sync.sv
module dmfifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dmfifo_mem.sv
module dmfifo_mem #(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] store [ENTRIES];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dmfifo_wr_side.sv
module dmfifo_wr_side
    import dmfifo_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          wr_en,
    input  logic [AW:0]   rptr_gray_s,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wptr_gray,
    output logic [AW:0]   level,
    output logic          wr_flag,
    output logic          half_flag
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);
    localparam logic [PW-1:0] HALF_V  = PW'(1 << (AW - 1));

    rd_mode_e      mode_q;
    logic [PW-1:0] wptr_bin;
    logic [PW-1:0] wptr_nxt;
    logic [PW-1:0] rptr_bin_s;
    logic          full;
    logic          rst;

    assign rst = !mrst_n || !prst_n;

    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign rptr_bin_s[i] = ^rptr_gray_s[PW-1:i];
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= rd_mode_e'(mode_sel);
        end
    end

    assign level    = wptr_bin - rptr_bin_s;
    assign full     = (level == DEPTH_V);
    assign wr_fire  = wr_en && !full && !rst;
    assign wr_addr  = wptr_bin[AW-1:0];
    assign wptr_nxt = wptr_bin + PW'(wr_fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_bin  <= '0;
            wptr_gray <= '0;
        end else begin
            wptr_bin  <= wptr_nxt;
            wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    always_comb begin
        unique case (mode_q)
            MODE_STD:  wr_flag = full;
            MODE_FWFT: wr_flag = !full;
            default:   wr_flag = full;
        endcase
        half_flag = (level > HALF_V);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTH_V); // R6
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && level == DEPTH_V) |=> (wptr_bin == $past(wptr_bin))); // R6
    AST_WR_MODE_HELD: assert property (@(posedge clk) disable iff (!mrst_n)
        mrst_n |=> $stable(mode_q)); // R1
endmodule

// File: rtl/dmfifo_rd_side.sv
module dmfifo_rd_side
    import dmfifo_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          rd_en,
    input  logic          rt_n,
    input  logic [AW:0]   wptr_gray_s,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rptr_gray,
    output logic [DW-1:0] dout_q,
    output logic          rd_flag
);
    localparam int PW = AW + 1;

    rd_mode_e      mode_q;
    rd_state_e     state_q;
    rd_state_e     state_nxt;
    logic [PW-1:0] rptr_bin;
    logic [PW-1:0] rptr_nxt;
    logic [PW-1:0] wptr_bin_s;
    logic          arr_empty;
    logic          pop;
    logic          rewind;
    logic          rst;

    assign rst    = !mrst_n || !prst_n;
    assign rewind = !rt_n;

    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign wptr_bin_s[i] = ^wptr_gray_s[PW-1:i];
    end

    assign arr_empty = (rptr_bin == wptr_bin_s);
    assign rd_addr   = rptr_bin[AW-1:0];

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= rd_mode_e'(mode_sel);
        end
    end

    // next-state and fetch decision
    always_comb begin
        pop       = 1'b0;
        state_nxt = state_q;
        unique case (mode_q)
            MODE_STD: begin
                pop       = rd_en && !arr_empty;
                state_nxt = RS_DRAINED;
            end
            MODE_FWFT: begin
                unique case (state_q)
                    RS_DRAINED: begin
                        pop       = !arr_empty;
                        state_nxt = arr_empty ? RS_DRAINED : RS_HOLDING;
                    end
                    RS_HOLDING: begin
                        if (rd_en) begin
                            pop       = !arr_empty;
                            state_nxt = arr_empty ? RS_DRAINED : RS_HOLDING;
                        end
                    end
                    default: state_nxt = RS_DRAINED;
                endcase
            end
            default: state_nxt = RS_DRAINED;
        endcase
        if (rewind) begin
            pop       = 1'b0;
            state_nxt = RS_DRAINED;
        end
        rptr_nxt = rewind ? '0 : rptr_bin + PW'(pop);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RS_DRAINED;
            rptr_bin  <= '0;
            rptr_gray <= '0;
            dout_q    <= '0;
        end else begin
            state_q   <= state_nxt;
            rptr_bin  <= rptr_nxt;
            rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
            if (pop) begin
                dout_q <= mem_rdata;
            end
        end
    end

    // status output
    always_comb begin
        unique case (mode_q)
            MODE_STD:  rd_flag = arr_empty;
            MODE_FWFT: rd_flag = (state_q == RS_HOLDING);
            default:   rd_flag = arr_empty;
        endcase
    end

    AST_EMPTY_BLOCKS_READ: assert property (@(posedge clk) disable iff (rst)
        (rt_n && arr_empty && (mode_q == MODE_STD || state_q == RS_DRAINED))
        |=> (rptr_bin == $past(rptr_bin) && dout_q == $past(dout_q))); // R7
    AST_REWIND_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rt_n |=> (rptr_bin == '0)); // R9
    AST_RD_MODE_HELD: assert property (@(posedge clk) disable iff (!mrst_n)
        mrst_n |=> $stable(mode_q)); // R1
    AST_STD_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STD) |=> (state_q == RS_DRAINED)); // R4
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
    parameter int DW    = 18,
    parameter int DEPTH = 512
) (
    input  logic                     wr_clk,
    input  logic                     rd_clk,
    input  logic                     mrst_n,
    input  logic                     prst_n,
    input  logic                     mode_sel,
    input  logic                     wr_en,
    input  logic [DW-1:0]            din,
    input  logic                     rd_en,
    input  logic                     rt_n,
    input  logic                     oe,
    output logic [DW-1:0]            dout,
    output logic                     rd_flag,
    output logic                     wr_flag,
    output logic                     half_flag,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          wr_fire;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [PW-1:0] wptr_gray;
    logic [PW-1:0] rptr_gray;
    logic [PW-1:0] wptr_gray_s;
    logic [PW-1:0] rptr_gray_s;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] dout_q;
    logic          rd_rst;
    logic          wr_rst;

    assign rd_rst = !mrst_n || !prst_n;
    assign wr_rst = !mrst_n || !prst_n;

    dmfifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wr_clk (wr_clk),
        .we     (wr_fire),
        .waddr  (wr_addr),
        .wdata  (din),
        .raddr  (rd_addr),
        .rdata  (mem_rdata)
    );

    dmfifo_sync #(.W(PW)) u_w2r (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wptr_gray),
        .q   (wptr_gray_s)
    );

    dmfifo_sync #(.W(PW)) u_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rptr_gray),
        .q   (rptr_gray_s)
    );

    dmfifo_wr_side #(.AW(AW)) u_wr (
        .clk         (wr_clk),
        .mrst_n      (mrst_n),
        .prst_n      (prst_n),
        .mode_sel    (mode_sel),
        .wr_en       (wr_en),
        .rptr_gray_s (rptr_gray_s),
        .wr_fire     (wr_fire),
        .wr_addr     (wr_addr),
        .wptr_gray   (wptr_gray),
        .level       (level),
        .wr_flag     (wr_flag),
        .half_flag   (half_flag)
    );

    dmfifo_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .clk         (rd_clk),
        .mrst_n      (mrst_n),
        .prst_n      (prst_n),
        .mode_sel    (mode_sel),
        .rd_en       (rd_en),
        .rt_n        (rt_n),
        .wptr_gray_s (wptr_gray_s),
        .mem_rdata   (mem_rdata),
        .rd_addr     (rd_addr),
        .rptr_gray   (rptr_gray),
        .dout_q      (dout_q),
        .rd_flag     (rd_flag)
    );

    assign dout = oe ? dout_q : '0;
endmodule

// File: tb/dual_mode_fifo_bench.sv
module dual_mode_fifo_bench;
    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          mode_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic          rd_en = 1'b0;
    logic          rt_n = 1'b1;
    logic          oe = 1'b1;
    logic [DW-1:0] dout;
    logic          rd_flag;
    logic          wr_flag;
    logic          half_flag;
    logic [LW-1:0] level;

    int n_chk  = 0;
    int n_fail = 0;

    dual_mode_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dual_mode_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_sel(mode_sel), .wr_en(wr_en), .din(din), .rd_en(rd_en),
        .rt_n(rt_n), .oe(oe), .dout(dout), .rd_flag(rd_flag),
        .wr_flag(wr_flag), .half_flag(half_flag), .level(level)
    );

    always #10 wr_clk = ~wr_clk;
    initial begin
        #5;
        forever #10 rd_clk = ~rd_clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] wval(input int n);
        return DW'(8'h30 + n);
    endfunction

    task automatic settle();
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic do_mrst(input logic m);
        @(negedge wr_clk);
        mrst_n = 1'b0;
        mode_sel = m;
        repeat (3) @(negedge rd_clk);
        repeat (3) @(negedge wr_clk);
        mrst_n = 1'b1;
        mode_sel = ~m;
        settle();
    endtask

    task automatic wr_word(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1;
        din = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic rt_pulse();
        @(negedge rd_clk);
        rt_n = 1'b0;
        @(negedge rd_clk);
        rt_n = 1'b1;
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            int cap;
            cap = DEPTH + m;
            do_mrst(m[0]);
            // R1 reset state per mode
            chk("R1 level", int'(level), 0);
            chk("R1 dout", int'(dout), 0);
            chk("R1 rd_flag", int'(rd_flag), (m == 0) ? 1 : 0);
            chk("R1 wr_flag", int'(wr_flag), (m == 0) ? 0 : 1);
            for (int n = 1; n <= cap + 1; n++) begin
                int stored, exp_lvl;
                wr_word(wval(n));
                settle();
                stored = (n < cap) ? n : cap;
                exp_lvl = (m == 1) ? stored - 1 : stored;
                if (m == 0 && n == 1) chk("R2 no fall-through", int'(dout), 0);
                chk("R11 level", int'(level), exp_lvl);
                chk("R5 half_flag", int'(half_flag), (exp_lvl > DEPTH / 2) ? 1 : 0);
                chk("R4 wr_flag", int'(wr_flag),
                    (m == 0) ? ((stored == cap) ? 1 : 0) : ((stored == cap) ? 0 : 1));
            end
            // drain; the word beyond capacity must not appear (R6, R12)
            for (int k = 1; k <= cap; k++) begin
                if (m == 0) begin
                    rd_pulse();
                    settle();
                    chk("R2 R12 read data", int'(dout), int'(wval(k)));
                end else begin
                    chk("R12 held data", int'(dout), int'(wval(k)));
                    chk("R4 output ready", int'(rd_flag), 1);
                    rd_pulse();
                    settle();
                end
            end
            chk("R6 dropped word absent", int'(level), 0);
            chk("R4 drained flag", int'(rd_flag), (m == 0) ? 1 : 0);
            // R7 read on empty
            rd_pulse();
            settle();
            chk("R7 dout unchanged", int'(dout), int'(wval(cap)));
            wr_word(wval(40));
            settle();
            if (m == 0) rd_pulse();
            settle();
            chk("R7 pointer kept", int'(dout), int'(wval(40)));
        end

        // R3 fall-through latency, edge by edge
        do_mrst(1'b1);
        wr_word(wval(50));
        @(negedge rd_clk);
        chk("R3 edge1 flag", int'(rd_flag), 0);
        @(negedge rd_clk);
        chk("R3 edge2 flag", int'(rd_flag), 0);
        @(negedge rd_clk);
        chk("R3 edge3 flag", int'(rd_flag), 1);
        chk("R3 edge3 data", int'(dout), int'(wval(50)));
        // R10 output enable
        oe = 1'b0;
        @(negedge rd_clk);
        chk("R10 oe low", int'(dout), 0);
        oe = 1'b1;
        @(negedge rd_clk);
        chk("R10 oe high", int'(dout), int'(wval(50)));

        // R8 partial reset keeps fall-through mode
        wr_word(wval(51));
        settle();
        @(negedge wr_clk);
        mode_sel = 1'b0;
        prst_n = 1'b0;
        repeat (3) @(negedge rd_clk);
        repeat (3) @(negedge wr_clk);
        prst_n = 1'b1;
        settle();
        chk("R8 level", int'(level), 0);
        chk("R8 rd_flag", int'(rd_flag), 0);
        chk("R8 wr_flag", int'(wr_flag), 1);
        chk("R8 dout", int'(dout), 0);
        wr_word(wval(52));
        settle();
        chk("R8 still fall-through", int'(dout), int'(wval(52)));

        // R9 rewind in both modes
        for (int m = 0; m < 2; m++) begin
            do_mrst(m[0]);
            for (int k = 1; k <= 3; k++) wr_word(wval(60 + k));
            settle();
            for (int k = 1; k <= 3; k++) begin
                rd_pulse();
                settle();
            end
            chk("R9 drained", int'(level), 0);
            rt_pulse();
            settle();
            chk("R9 level after rewind", int'(level), (m == 0) ? 3 : 2);
            if (m == 0) begin
                rd_pulse();
                settle();
            end
            chk("R9 replay first", int'(dout), int'(wval(61)));
            rd_pulse();
            settle();
            if (m == 0) chk("R9 replay second", int'(dout), int'(wval(62)));
            else chk("R9 replay second", int'(dout), int'(wval(62)));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule